// File: doc/BRIEF.md
# Two-Channel Serial Converter Output Port

This block is the digital side of a two-input serial converter. A host drives two pins: a convert-start line and a serial clock. It reads results back on one data pin that can be driven or left floating. A falling edge of convert-start opens a short selection window. If another clean pulse arrives on the same line inside that window, the second input is chosen instead of the first. When the window closes, the chosen input's 8-bit value is latched and a fixed conversion time is counted out. This timer stands in for the analog successive-approximation period.

During selection and conversion the data pin is driven low. When the timer expires, the most significant bit of the latched value appears on the pin at once. Each falling serial clock edge then moves the pin to the next lower bit. After the eighth rising serial clock edge the pin is released. Both host pins are asynchronous to the block clock: they are synchronised, and convert-start high times that are too short are filtered out. A clean start edge arriving at any point, including during a read, abandons the current transaction and begins a new one.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, and whenever no transaction is active, the output enable `serDataEn` is 0.
- R2: A falling edge of `cnvStart` that follows a high time of at least MIN_HIGH_CYC clock cycles starts a transaction. Within a few cycles `serDataEn` is 1 and `serData` is 0.
- R3: A `cnvStart` high time shorter than MIN_HIGH_CYC cycles has no effect. It does not start a transaction, does not change the channel, and does not disturb a read in progress.
- R4: If a second valid `cnvStart` pulse ends within SEL_WIN_CYC cycles of the starting edge, channel 1 (`sampleCh1`) is converted. Otherwise channel 0 (`sampleCh0`) is converted.
- R5: For the SEL_WIN_CYC selection cycles and the CONV_CYC conversion cycles that follow, `serDataEn` is 1 and `serData` is 0.
- R6: When conversion ends, `serData` shows bit 7 (the MSB) of the result with no serial clock edge needed.
- R7: The sample is taken when the selection window closes. Later changes on the sample inputs do not alter the result being read.
- R8: Each falling edge of `serClk` moves `serData` to the next lower bit, so bits appear in the order 7 down to 0 as plain unsigned binary. A rising edge leaves `serData` unchanged.
- R9: On the eighth rising edge of `serClk` after conversion ends, `serDataEn` returns to 0 and stays there until the next valid start.
- R10: Serial clock edges during selection or conversion are ignored, and the later read still delivers all 8 bits starting at the MSB.
- R11: A valid start during a read abandons that read: `serData` is forced to 0 with `serDataEn` at 1, and a fresh selection and conversion follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cnvStart | input | 1 | Asynchronous convert-start line from the host |
| serClk | input | 1 | Asynchronous serial clock from the host |
| sampleCh0 | input | DATA_W | Digitised value of input channel 0 |
| sampleCh1 | input | DATA_W | Digitised value of input channel 1 |
| serData | output | 1 | Serial data bit (valid when enabled) |
| serDataEn | output | 1 | Output enable for the three-state data pin |

## Verification
The hardest situation to reach from the ports is a start edge that lands in the middle of a read. The pin is then showing a 1 bit, and it has to be seen being forced back to 0 before the channel is chosen again. The stimulus loads an all-ones sample, clocks out part of it, and then issues a new double pulse that selects the other channel. It checks that the pin drops low and that the new channel's value is then read out. Runt pulses are placed deliberately inside the selection window and in the middle of a read. Serial clock edges are placed inside the conversion time. Randomised transactions with mixed channels and values, drawn from a fixed seed, cover the remaining data patterns.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SELECT  = 2'd1,
    ST_CONVERT = 2'd2,
    ST_SHIFT   = 2'd3
  } ctrlState_t;

  typedef enum logic [1:0] {
    DRV_OFF  = 2'd0,
    DRV_LOW  = 2'd1,
    DRV_DATA = 2'd2
  } drvMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     capture;
    logic     useCh1;
    logic     shift;
    drvMode_t drive;
  } dpStrobe_t;

endpackage

// File: rtl/adc_sp_front.sv
module adc_sp_front #(
  parameter int SYNC_STAGES  = 2,
  parameter int MIN_HIGH_CYC = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic cnvStartIn,
  input  logic serClkIn,
  output logic startValid,
  output logic sclkRise,
  output logic sclkFall
);

  localparam int HI_W = (MIN_HIGH_CYC < 1) ? 1 : $clog2(MIN_HIGH_CYC + 1);

  // index 0 is the newest stage, index SYNC_STAGES is the edge history
  logic [SYNC_STAGES:0] startPipe;
  logic [SYNC_STAGES:0] clkPipe;
  logic startLvl, startPrev, clkLvl, clkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startPipe <= '0;
      clkPipe   <= '0;
    end else begin
      startPipe <= {startPipe[SYNC_STAGES-1:0], cnvStartIn};
      clkPipe   <= {clkPipe[SYNC_STAGES-1:0], serClkIn};
    end
  end

  assign startLvl  = startPipe[SYNC_STAGES-1];
  assign startPrev = startPipe[SYNC_STAGES];
  assign clkLvl    = clkPipe[SYNC_STAGES-1];
  assign clkPrev   = clkPipe[SYNC_STAGES];

  assign sclkRise = clkLvl & ~clkPrev;
  assign sclkFall = ~clkLvl & clkPrev;

  generate
    if (MIN_HIGH_CYC > 0) begin : g_filter
      logic [HI_W-1:0] hiCnt;
      logic            hiLongEnough;

      // counts synchronised high cycles, saturating at the threshold
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          hiCnt <= '0;
        end else if (!startLvl) begin
          hiCnt <= '0;
        end else if (hiCnt != HI_W'(MIN_HIGH_CYC)) begin
          hiCnt <= hiCnt + 1'b1;
        end
      end

      assign hiLongEnough = (hiCnt == HI_W'(MIN_HIGH_CYC));
      assign startValid   = startPrev & ~startLvl & hiLongEnough;
    end else begin : g_nofilter
      assign startValid = startPrev & ~startLvl;
    end
  endgenerate

endmodule

// File: rtl/adc_sp_ctrl.sv
module adc_sp_ctrl
  import adc_sp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SEL_WIN_CYC = 40,
  parameter int CONV_CYC    = 750
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startValid,
  input  logic       sclkRise,
  input  logic       sclkFall,
  output dpStrobe_t  strobe
);

  localparam int TMR_MAX = (SEL_WIN_CYC > CONV_CYC) ? SEL_WIN_CYC : CONV_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int BIT_W   = $clog2(DATA_W + 1);

  ctrlState_t       stateQ, stateD;
  logic [TMR_W-1:0] tmrQ, tmrD;
  logic [BIT_W-1:0] riseQ, riseD;
  logic             ch1Q, ch1D;
  logic             captureD, shiftD;

  always_comb begin
    stateD   = stateQ;
    tmrD     = tmrQ;
    riseD    = riseQ;
    ch1D     = ch1Q;
    captureD = 1'b0;
    shiftD   = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (startValid) begin
          stateD = ST_SELECT;
          tmrD   = '0;
          ch1D   = 1'b0;
        end
      end
      ST_SELECT: begin
        if (startValid) ch1D = 1'b1;
        if (tmrQ == TMR_W'(SEL_WIN_CYC - 1)) begin
          stateD   = ST_CONVERT;
          tmrD     = '0;
          captureD = 1'b1;
        end else begin
          tmrD = tmrQ + 1'b1;
        end
      end
      ST_CONVERT: begin
        if (startValid) begin
          stateD = ST_SELECT;
          tmrD   = '0;
          ch1D   = 1'b0;
        end else if (tmrQ == TMR_W'(CONV_CYC - 1)) begin
          stateD = ST_SHIFT;
          riseD  = '0;
        end else begin
          tmrD = tmrQ + 1'b1;
        end
      end
      ST_SHIFT: begin
        if (startValid) begin
          stateD = ST_SELECT;
          tmrD   = '0;
          ch1D   = 1'b0;
        end else begin
          if (sclkFall) shiftD = 1'b1;
          if (sclkRise) begin
            if (riseQ == BIT_W'(DATA_W - 1)) begin
              stateD = ST_IDLE;
            end else begin
              riseD = riseQ + 1'b1;
            end
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      tmrQ   <= '0;
      riseQ  <= '0;
      ch1Q   <= 1'b0;
    end else begin
      stateQ <= stateD;
      tmrQ   <= tmrD;
      riseQ  <= riseD;
      ch1Q   <= ch1D;
    end
  end

  always_comb begin
    strobe.capture = captureD;
    strobe.useCh1  = ch1D;
    strobe.shift   = shiftD;
    unique case (stateQ)
      ST_SELECT, ST_CONVERT: strobe.drive = DRV_LOW;
      ST_SHIFT:              strobe.drive = DRV_DATA;
      default:               strobe.drive = DRV_OFF;
    endcase
  end

endmodule

// File: rtl/adc_sp_dp.sv
module adc_sp_dp
  import adc_sp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] sampleCh0,
  input  logic [DATA_W-1:0] sampleCh1,
  input  dpStrobe_t         strobe,
  output logic              serData,
  output logic              serDataEn
);

  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] chosen;

  assign chosen = strobe.useCh1 ? sampleCh1 : sampleCh0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.capture) begin
      shiftReg <= chosen;
    end else if (strobe.shift) begin
      shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
    end
  end

  assign serData   = (strobe.drive == DRV_DATA) & shiftReg[DATA_W-1];
  assign serDataEn = (strobe.drive != DRV_OFF);

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_sp_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int MIN_HIGH_CYC = 5,
  parameter int SEL_WIN_CYC  = 40,
  parameter int CONV_CYC     = 750
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cnvStart,
  input  logic              serClk,
  input  logic [DATA_W-1:0] sampleCh0,
  input  logic [DATA_W-1:0] sampleCh1,
  output logic              serData,
  output logic              serDataEn
);

  logic      startValid;
  logic      sclkRise;
  logic      sclkFall;
  dpStrobe_t strobe;

  adc_sp_front #(
    .SYNC_STAGES (SYNC_STAGES),
    .MIN_HIGH_CYC(MIN_HIGH_CYC)
  ) u_front (
    .clk       (clk),
    .rstN      (rstN),
    .cnvStartIn(cnvStart),
    .serClkIn  (serClk),
    .startValid(startValid),
    .sclkRise  (sclkRise),
    .sclkFall  (sclkFall)
  );

  adc_sp_ctrl #(
    .DATA_W     (DATA_W),
    .SEL_WIN_CYC(SEL_WIN_CYC),
    .CONV_CYC   (CONV_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startValid(startValid),
    .sclkRise  (sclkRise),
    .sclkFall  (sclkFall),
    .strobe    (strobe)
  );

  adc_sp_dp #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sampleCh0(sampleCh0),
    .sampleCh1(sampleCh1),
    .strobe   (strobe),
    .serData  (serData),
    .serDataEn(serDataEn)
  );

endmodule

// File: rtl/adc_sp_chk.sv
module adc_sp_chk
  import adc_sp_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       serData,
  input logic       serDataEn,
  input logic       startValid,
  input logic       sclkRise,
  input logic       sclkFall,
  input ctrlState_t ctrlState
);

  // R1
  idle_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_IDLE) |-> !serDataEn);

  // R2
  start_drives_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    startValid |=> (serDataEn && !serData));

  // R5
  convert_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_CONVERT) |-> (serDataEn && !serData));

  // R8
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_SHIFT && $past(ctrlState) == ST_SHIFT && !$past(sclkFall))
      |-> $stable(serData));

  // R9
  release_after_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(serDataEn) |-> ($past(ctrlState) == ST_SHIFT && $past(sclkRise)));

  // R10
  convert_ignores_sclk_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_CONVERT && !startValid)
      |=> (ctrlState == ST_CONVERT || ctrlState == ST_SHIFT));

endmodule

bind adc_serial_port adc_sp_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .serData   (serData),
  .serDataEn (serDataEn),
  .startValid(startValid),
  .sclkRise  (sclkRise),
  .sclkFall  (sclkFall),
  .ctrlState (u_ctrl.stateQ)
);

// File: tb/adc_serial_port_tb.sv
`timescale 1ns/1ps
module adc_serial_port_tb;

  localparam int DATA_W       = 8;
  localparam int MIN_HIGH_CYC = 5;
  localparam int SEL_WIN_CYC  = 40;
  localparam int CONV_CYC     = 750;
  localparam int HALF         = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cnvStart = 1'b0;
  logic serClk = 1'b0;
  logic [DATA_W-1:0] sampleCh0 = '0;
  logic [DATA_W-1:0] sampleCh1 = '0;
  logic serData, serDataEn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  adc_serial_port #(
    .DATA_W      (DATA_W),
    .SYNC_STAGES (2),
    .MIN_HIGH_CYC(MIN_HIGH_CYC),
    .SEL_WIN_CYC (SEL_WIN_CYC),
    .CONV_CYC    (CONV_CYC)
  ) u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .cnvStart (cnvStart),
    .serClk   (serClk),
    .sampleCh0(sampleCh0),
    .sampleCh1(sampleCh1),
    .serData  (serData),
    .serDataEn(serDataEn)
  );

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DATA_W-1:0] pickExpected(input bit ch1, input bit runt,
                                                     input logic [DATA_W-1:0] v0,
                                                     input logic [DATA_W-1:0] v1);
    return (ch1 && !runt) ? v1 : v0;
  endfunction

  task automatic startPulse(input int hi);
    cnvStart = 1'b1;
    waitCyc(hi);
    cnvStart = 1'b0;
  endtask

  task automatic sclkCycle();
    serClk = 1'b1;
    waitCyc(HALF);
    serClk = 1'b0;
    waitCyc(HALF);
  endtask

  // Starts a transaction; returns once the MSB should be on the pin.
  task automatic startAndConvert(input bit ch1, input bit runt, input bit sclkNoise,
                                 input logic [DATA_W-1:0] v0, input logic [DATA_W-1:0] v1,
                                 output logic [DATA_W-1:0] expVal);
    int elapsed;
    sampleCh0 = v0;
    sampleCh1 = v1;
    expVal = pickExpected(ch1, runt, v0, v1);
    startPulse(10);
    waitCyc(4);
    check("R2/R11 driven low after start", {serDataEn, serData}, 2'b10);
    elapsed = 4;
    if (ch1) begin
      // a runt second pulse must not switch the channel (R3)
      startPulse(runt ? 2 : 10);
      elapsed += runt ? 2 : 10;
    end
    waitCyc(SEL_WIN_CYC + 10 - elapsed);
    // change inputs after capture: R7
    sampleCh0 = ~v0;
    sampleCh1 = ~v1;
    check("R5 low during conversion", {serDataEn, serData}, 2'b10);
    if (sclkNoise) begin
      // R10: serial clock toggles while converting
      for (int k = 0; k < 3; k++) sclkCycle();
      waitCyc(CONV_CYC / 2 - 3 * 2 * HALF);
    end else begin
      waitCyc(CONV_CYC / 2);
    end
    check("R5 low mid conversion", {serDataEn, serData}, 2'b10);
    waitCyc(CONV_CYC - CONV_CYC / 2 - 10);
    check("R5 low near conversion end", {serDataEn, serData}, 2'b10);
    waitCyc(5);
    check("R6 MSB shown without clock", {serDataEn, serData}, {1'b1, expVal[DATA_W-1]});
  endtask

  // Reads nBits of the value; full reads also check release.
  task automatic readOut(input logic [DATA_W-1:0] expVal, input int nBits, input bit runtMid);
    for (int i = DATA_W - 2; i >= DATA_W - 1 - nBits && i >= 0; i--) begin
      serClk = 1'b1;
      waitCyc(HALF);
      check("R8 bit steady across rising edge", {serDataEn, serData}, {1'b1, expVal[i+1]});
      serClk = 1'b0;
      waitCyc(HALF);
      if (runtMid && i == 3) begin
        startPulse(2);
        waitCyc(HALF);
        check("R3 runt pulse leaves read intact", {serDataEn, serData}, {1'b1, expVal[i]});
      end
      check("R8 next bit after falling edge", {serDataEn, serData}, {1'b1, expVal[i]});
    end
    if (nBits >= DATA_W - 1) begin
      serClk = 1'b1;
      waitCyc(HALF);
      check("R9 released after eighth rise", serDataEn, 1'b0);
      serClk = 1'b0;
      waitCyc(HALF);
      sclkCycle();
      check("R9 stays released", serDataEn, 1'b0);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stimulus
    logic [DATA_W-1:0] expVal;
    logic [DATA_W-1:0] r0, r1;
    bit rc;
    void'($urandom(32'h5eed_1234));

    waitCyc(5);
    rstN = 1'b1;
    waitCyc(3);
    check("R1 released after reset", serDataEn, 1'b0);

    // R3: runt pulse while idle
    startPulse(2);
    waitCyc(20);
    check("R3 runt pulse while idle ignored", serDataEn, 1'b0);

    // R4: channel 0 then channel 1, directed
    startAndConvert(1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C, expVal);
    readOut(expVal, DATA_W - 1, 1'b0);
    startAndConvert(1'b1, 1'b0, 1'b0, 8'hA5, 8'h3C, expVal);
    check("R4 second pulse selects channel 1", expVal, 8'h3C);
    readOut(expVal, DATA_W - 1, 1'b0);

    // R3/R4: runt second pulse keeps channel 0
    startAndConvert(1'b1, 1'b1, 1'b0, 8'h81, 8'h7E, expVal);
    readOut(expVal, DATA_W - 1, 1'b0);

    // R10: serial clock noise during conversion
    startAndConvert(1'b0, 1'b0, 1'b1, 8'hC3, 8'h00, expVal);
    readOut(expVal, DATA_W - 1, 1'b0);

    // R3: runt pulse in the middle of a read
    startAndConvert(1'b1, 1'b0, 1'b0, 8'h00, 8'hB6, expVal);
    readOut(expVal, DATA_W - 1, 1'b1);

    // R11: abort a read that is showing a 1, restart on channel 1
    startAndConvert(1'b0, 1'b0, 1'b0, 8'hFF, 8'h00, expVal);
    readOut(expVal, 3, 1'b0);
    check("R11 pin high before abort", {serDataEn, serData}, 2'b11);
    startAndConvert(1'b1, 1'b0, 1'b0, 8'hFF, 8'h5A, expVal);
    readOut(expVal, DATA_W - 1, 1'b0);

    // boundary values
    startAndConvert(1'b0, 1'b0, 1'b0, 8'h00, 8'hFF, expVal);
    readOut(expVal, DATA_W - 1, 1'b0);
    startAndConvert(1'b1, 1'b0, 1'b0, 8'h00, 8'hFF, expVal);
    readOut(expVal, DATA_W - 1, 1'b0);

    // R7/R8: constrained random transactions
    for (int n = 0; n < 16; n++) begin
      r0 = DATA_W'($urandom);
      r1 = DATA_W'($urandom);
      rc = 1'($urandom);
      startAndConvert(rc, 1'b0, 1'($urandom), r0, r1, expVal);
      readOut(expVal, DATA_W - 1, 1'b0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule